// File: doc/BRIEF.md
# Descriptor QoS Classifier

This stage accepts one decoded receive descriptor per handshake and turns its switch-side priority and routing fields into transmit classification results. It picks a traffic identifier (TID) and states whether that TID overwrites the default. It also produces a flow-override bit with its own enable, a two-bit classify-info select and a frame colour. It checks the destination and source routing words and looks up the attributes of virtual ports in a programmable table. Two of those attributes are enables that gate the priority-table TID path and the drop-precedence colour path.

Two small tables are loaded through a write port that takes an address, data and a table select. The first maps the 4-bit internal priority to a 3-bit TID. The second holds one entry for each virtual port. The classified result sits in an output register that advances only when a descriptor is accepted.

Top module: `qos_desc_classifier`

## Requirements
- R1: `in_ready` is high exactly when the output register is empty or `out_ready` is high. A descriptor is captured when `in_valid` and `in_ready` are both high, and `out_valid` is high in the next cycle. While `out_valid` is high and `out_ready` is low, every output holds.
- R2: When `in_qos_flag` is 1, the outputs are set as follows: `out_cls_sel` = qos[5:4], `out_tid` = qos[3:1], `out_flow` = qos[0], and both `out_tid_en` and `out_flow_en` are 1.
- R3: When `in_qos_flag` is 0 and qos[7] is 1, `out_tid` = qos[3:1] and `out_tid_en` = 1. In this case `out_flow_en`, `out_flow` and `out_cls_sel` are all 0.
- R4: When `in_qos_flag` is 0, qos[7] is 0 and the destination virtual port has its priority-table enable set, `out_tid` is the TID table entry indexed by `in_int_pri`, and `out_tid_en` = 1.
- R5: When none of the conditions in R2 to R4 holds, `out_tid_en`, `out_tid`, `out_flow_en`, `out_flow` and `out_cls_sel` are all 0.
- R6: qos bit 6 has no effect on any output.
- R7: The colour output encodes green as 0, yellow as 1, red as 2 and colourless as 3. When the destination virtual port has its drop enable set and `in_drop_prec` is 0, 1 or 2, `out_color` equals `in_drop_prec`. In every other case `out_color` is 3.
- R8: The destination word is accepted only when bits [15:12] equal 2, and its port ID is taken from bits [11:0]. The other kinds are 0 (invalid), 1 (next hop) and 3 (bitmap); these, and any other nibble value, set `out_err`.
- R9: Port IDs 0 to 31 are physical ports; they carry zero attributes and both enables off. IDs 32 to 63 set `out_err`. IDs 64 to 255 use attribute entry ID−64, and `out_bank`, `out_vdev` and `out_to_fw` come from that entry. IDs of 256 and above set `out_err`.
- R10: The source word must have bits [15:12] = 2 and bits [11:0] ≤ 255; any other value sets `out_err`.
- R11: When `out_err` is 1, `out_color` is 3 and every other classification output is 0.
- R12: A write with `cfg_we` = 1 goes to one of two tables. With `cfg_tbl` = 0 it loads TID entry `cfg_addr` (0..15) from `cfg_data[2:0]`. With `cfg_tbl` = 1 it loads virtual-port entry `cfg_addr` (0..191) from `cfg_data`, packed as {prio_en[16], drop_en[15], to_fw[14], vdev[13:6], bank[5:0]}. A write to an address beyond the table is ignored. A descriptor accepted in the same cycle as a write sees the old contents.
- R13: Reset empties the output register (`out_valid` = 0, `in_ready` = 1) and clears both tables to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Stage can take a descriptor |
| in_drop_prec | input | 2 | Drop precedence |
| in_qos_flag | input | 1 | Explicit QoS override flag |
| in_qos | input | 8 | QoS byte |
| in_int_pri | input | PRI_W | Internal priority |
| in_dst_word | input | 16 | Destination routing word |
| in_src_word | input | 16 | Source routing word |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 = TID table, 1 = virtual-port table |
| cfg_addr | input | CFG_AW | Table entry address |
| cfg_data | input | BANK_W+VDEV_W+3 | Write data |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_err | output | 1 | Routing word unsupported |
| out_tid | output | TID_W | Traffic identifier |
| out_tid_en | output | 1 | TID overwrite enable |
| out_flow | output | 1 | Flow-override bit |
| out_flow_en | output | 1 | Flow-override enable |
| out_cls_sel | output | 2 | Classify-info select |
| out_color | output | 2 | Frame colour |
| out_port_id | output | 8 | Destination port ID |
| out_bank | output | BANK_W | Bank ID of virtual port |
| out_vdev | output | VDEV_W | Virtual device ID |
| out_to_fw | output | 1 | Send-to-firmware bit |

## Verification
The hardest situation to reach from the ports combines two events in one cycle. A descriptor is accepted for a virtual port while that same port's attribute entry is being rewritten, and this happens while the output is stalled by `out_ready`. The stimulus keeps table writes running at random during traffic and biases destinations toward a few virtual ports so that these collisions occur. It toggles `out_ready` so that stalls overlap them. It also writes to addresses past the end of each table, then addresses the entries that a truncated address would have hit. Finally, it sends descriptor pairs that differ only in qos bit 6.

// File: rtl/qc_pkg.sv
package qc_pkg;
   // colour codes on the output
   typedef enum logic [1:0] {
      COL_GREEN  = 2'd0,
      COL_YELLOW = 2'd1,
      COL_RED    = 2'd2,
      COL_NONE   = 2'd3
   } colour_t;

   // meaning of a routing word's upper nibble
   typedef enum logic [3:0] {
      RT_INVALID = 4'd0,
      RT_NEXTHOP = 4'd1,
      RT_PORT    = 4'd2,
      RT_BITMAP  = 4'd3
   } route_kind_t;

   localparam int ROUTE_W    = 16;
   localparam int PORT_ID_W  = 12;
   localparam int PHYS_LIMIT = 32;
   localparam int VPORT_BASE = 64;
   localparam int OUT_PORT_W = 8;
endpackage

// File: rtl/qc_route_decode.sv
module qc_route_decode
   import qc_pkg::*;
#(
   parameter int VPORT_DEPTH = 192,
   localparam int VA_W = (VPORT_DEPTH > 1) ? $clog2(VPORT_DEPTH) : 1
) (
   input  logic [ROUTE_W-1:0]    dst_word,
   input  logic [ROUTE_W-1:0]    src_word,
   output logic                  route_ok,
   output logic                  is_vport,
   output logic [VA_W-1:0]       vport_idx,
   output logic [OUT_PORT_W-1:0] port_id
);
   localparam int PORT_LIMIT = VPORT_BASE + VPORT_DEPTH;

   logic [PORT_ID_W-1:0] dst_id;
   logic [PORT_ID_W-1:0] src_id;
   logic                 dst_kind_ok;
   logic                 src_kind_ok;
   logic                 dst_phys;
   logic                 dst_virt;
   logic                 src_range_ok;

   assign dst_id = dst_word[PORT_ID_W-1:0];
   assign src_id = src_word[PORT_ID_W-1:0];

   assign dst_kind_ok = (route_kind_t'(dst_word[ROUTE_W-1 -: 4]) == RT_PORT);
   assign src_kind_ok = (route_kind_t'(src_word[ROUTE_W-1 -: 4]) == RT_PORT);

   assign dst_phys     = (32'(dst_id) < PHYS_LIMIT);
   assign dst_virt     = (32'(dst_id) >= VPORT_BASE) && (32'(dst_id) < PORT_LIMIT);
   assign src_range_ok = (32'(src_id) < PORT_LIMIT);

   assign route_ok  = dst_kind_ok && (dst_phys || dst_virt) && src_kind_ok && src_range_ok;
   assign is_vport  = dst_kind_ok && dst_virt;
   assign vport_idx = VA_W'(dst_id - PORT_ID_W'(VPORT_BASE));
   assign port_id   = OUT_PORT_W'(dst_id);
endmodule

// File: rtl/qc_tid_map.sv
module qc_tid_map #(
   parameter int PRI_W = 4,
   parameter int TID_W = 3,
   localparam int DEPTH = 1 << PRI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [PRI_W-1:0] waddr,
   input  logic [TID_W-1:0] wdata,
   input  logic [PRI_W-1:0] raddr,
   output logic [TID_W-1:0] rdata
);
   logic [TID_W-1:0] tbl [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else if (we) begin
         tbl[waddr] <= wdata;
      end
   end

   assign rdata = tbl[raddr];
endmodule

// File: rtl/qc_port_attr.sv
module qc_port_attr #(
   parameter int DEPTH  = 192,
   parameter int ATTR_W = 17,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [ATTR_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [ATTR_W-1:0] rdata
);
   logic [ATTR_W-1:0] tbl [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (we && (waddr == AW'(i))) tbl[i] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (raddr == AW'(i)) rdata = tbl[i];
      end
   end
endmodule

// File: rtl/qc_prio_resolve.sv
module qc_prio_resolve #(
   parameter int TID_W = 3
) (
   input  logic             qos_flag,
   input  logic [7:0]       qos,
   input  logic             prio_en,
   input  logic [TID_W-1:0] map_tid,
   output logic [TID_W-1:0] tid,
   output logic             tid_en,
   output logic             flow,
   output logic             flow_en,
   output logic [1:0]       cls_sel
);
   // bit 6 carries no meaning for classification
   logic qos_b6_unused;
   assign qos_b6_unused = qos[6];

   // precedence: explicit flag, then top QoS bit, then per-port table
   always_comb begin
      tid     = '0;
      tid_en  = 1'b0;
      flow    = 1'b0;
      flow_en = 1'b0;
      cls_sel = 2'b00;
      if (qos_flag) begin
         cls_sel = qos[5:4];
         tid     = TID_W'(qos[3:1]);
         flow    = qos[0];
         tid_en  = 1'b1;
         flow_en = 1'b1;
      end else if (qos[7]) begin
         tid    = TID_W'(qos[3:1]);
         tid_en = 1'b1;
      end else if (prio_en) begin
         tid    = map_tid;
         tid_en = 1'b1;
      end
   end
endmodule

// File: rtl/qos_desc_classifier.sv
module qos_desc_classifier
   import qc_pkg::*;
#(
   parameter int TID_W       = 3,
   parameter int PRI_W       = 4,
   parameter int BANK_W      = 6,
   parameter int VDEV_W      = 8,
   parameter int VPORT_DEPTH = 192,
   parameter int CFG_AW      = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [1:0]                in_drop_prec,
   input  logic                      in_qos_flag,
   input  logic [7:0]                in_qos,
   input  logic [PRI_W-1:0]          in_int_pri,
   input  logic [15:0]               in_dst_word,
   input  logic [15:0]               in_src_word,
   input  logic                      cfg_we,
   input  logic                      cfg_tbl,
   input  logic [CFG_AW-1:0]         cfg_addr,
   input  logic [BANK_W+VDEV_W+2:0]  cfg_data,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic                      out_err,
   output logic [TID_W-1:0]          out_tid,
   output logic                      out_tid_en,
   output logic                      out_flow,
   output logic                      out_flow_en,
   output logic [1:0]                out_cls_sel,
   output logic [1:0]                out_color,
   output logic [7:0]                out_port_id,
   output logic [BANK_W-1:0]         out_bank,
   output logic [VDEV_W-1:0]         out_vdev,
   output logic                      out_to_fw
);
   localparam int ATTR_W    = BANK_W + VDEV_W + 3;
   localparam int TID_DEPTH = 1 << PRI_W;
   localparam int VA_W      = (VPORT_DEPTH > 1) ? $clog2(VPORT_DEPTH) : 1;
   localparam int FW_BIT    = BANK_W + VDEV_W;
   localparam int DROP_BIT  = FW_BIT + 1;
   localparam int PRIO_BIT  = FW_BIT + 2;

   // elaboration-time parameter checks
   if (TID_W < 3) begin : g_bad_tid
      $error("TID_W must hold a 3-bit QoS TID");
   end
   if (VA_W > CFG_AW || PRI_W > CFG_AW) begin : g_bad_aw
      $error("CFG_AW too narrow for table addresses");
   end
   if (TID_W > ATTR_W) begin : g_bad_cfgw
      $error("cfg_data too narrow for TID entries");
   end
   if (VPORT_BASE + VPORT_DEPTH > 256) begin : g_bad_depth
      $error("virtual ports must fit an 8-bit port ID");
   end

   // ---------------- write port steering ----------------
   logic tid_we;
   logic attr_we;
   assign tid_we  = cfg_we && !cfg_tbl && (32'(cfg_addr) < TID_DEPTH);
   assign attr_we = cfg_we &&  cfg_tbl && (32'(cfg_addr) < VPORT_DEPTH);

   // ---------------- routing decode ----------------
   logic            route_ok;
   logic            is_vport;
   logic [VA_W-1:0] vport_idx;
   logic [7:0]      port_id;

   qc_route_decode #(.VPORT_DEPTH(VPORT_DEPTH)) u_route (
      .dst_word  (in_dst_word),
      .src_word  (in_src_word),
      .route_ok  (route_ok),
      .is_vport  (is_vport),
      .vport_idx (vport_idx),
      .port_id   (port_id)
   );

   // ---------------- tables ----------------
   logic [ATTR_W-1:0] attr_raw;
   logic [TID_W-1:0]  map_tid;

   qc_port_attr #(.DEPTH(VPORT_DEPTH), .ATTR_W(ATTR_W)) u_attr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (attr_we),
      .waddr (cfg_addr[VA_W-1:0]),
      .wdata (cfg_data),
      .raddr (vport_idx),
      .rdata (attr_raw)
   );

   qc_tid_map #(.PRI_W(PRI_W), .TID_W(TID_W)) u_tid (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tid_we),
      .waddr (cfg_addr[PRI_W-1:0]),
      .wdata (cfg_data[TID_W-1:0]),
      .raddr (in_int_pri),
      .rdata (map_tid)
   );

   // physical ports carry no attributes
   logic [ATTR_W-1:0] attr;
   assign attr = is_vport ? attr_raw : '0;

   // ---------------- TID / flow resolution ----------------
   logic [TID_W-1:0] c_tid;
   logic             c_tid_en;
   logic             c_flow;
   logic             c_flow_en;
   logic [1:0]       c_cls;

   qc_prio_resolve #(.TID_W(TID_W)) u_prio (
      .qos_flag (in_qos_flag),
      .qos      (in_qos),
      .prio_en  (attr[PRIO_BIT]),
      .map_tid  (map_tid),
      .tid      (c_tid),
      .tid_en   (c_tid_en),
      .flow     (c_flow),
      .flow_en  (c_flow_en),
      .cls_sel  (c_cls)
   );

   // ---------------- colour ----------------
   colour_t c_col;
   always_comb begin
      c_col = COL_NONE;
      if (attr[DROP_BIT]) begin
         unique case (in_drop_prec)
            2'd0:    c_col = COL_GREEN;
            2'd1:    c_col = COL_YELLOW;
            2'd2:    c_col = COL_RED;
            default: c_col = COL_NONE;
         endcase
      end
   end

   // ---------------- output register ----------------
   logic accept;
   assign in_ready = !out_valid || out_ready;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_err     <= 1'b0;
         out_tid     <= '0;
         out_tid_en  <= 1'b0;
         out_flow    <= 1'b0;
         out_flow_en <= 1'b0;
         out_cls_sel <= 2'b00;
         out_color   <= COL_NONE;
         out_port_id <= '0;
         out_bank    <= '0;
         out_vdev    <= '0;
         out_to_fw   <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
         if (route_ok) begin
            out_err     <= 1'b0;
            out_tid     <= c_tid;
            out_tid_en  <= c_tid_en;
            out_flow    <= c_flow;
            out_flow_en <= c_flow_en;
            out_cls_sel <= c_cls;
            out_color   <= c_col;
            out_port_id <= port_id;
            out_bank    <= attr[BANK_W-1:0];
            out_vdev    <= attr[BANK_W +: VDEV_W];
            out_to_fw   <= attr[FW_BIT];
         end else begin
            out_err     <= 1'b1;
            out_tid     <= '0;
            out_tid_en  <= 1'b0;
            out_flow    <= 1'b0;
            out_flow_en <= 1'b0;
            out_cls_sel <= 2'b00;
            out_color   <= COL_NONE;
            out_port_id <= '0;
            out_bank    <= '0;
            out_vdev    <= '0;
            out_to_fw   <= 1'b0;
         end
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/qc_checker.sv
module qc_checker #(
   parameter int TID_W       = 3,
   parameter int PRI_W       = 4,
   parameter int BANK_W      = 6,
   parameter int VDEV_W      = 8,
   parameter int VPORT_DEPTH = 192,
   parameter int CFG_AW      = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_err,
   input logic [TID_W-1:0]  out_tid,
   input logic              out_tid_en,
   input logic              out_flow,
   input logic              out_flow_en,
   input logic [1:0]        out_cls_sel,
   input logic [1:0]        out_color,
   input logic [7:0]        out_port_id,
   input logic [BANK_W-1:0] out_bank,
   input logic [VDEV_W-1:0] out_vdev,
   input logic              out_to_fw
);
   // R1
   stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R1
   stall_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable({out_err, out_tid, out_tid_en,
         out_flow, out_flow_en, out_cls_sel, out_color, out_port_id, out_bank,
         out_vdev, out_to_fw})));

   // R1
   accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R2
   flow_needs_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flow_en) |-> out_tid_en);

   // R11
   error_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (!out_tid_en && !out_flow_en && out_color == 2'd3
         && !out_to_fw && out_bank == '0));

   // R13
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> !out_valid);
endmodule

bind qos_desc_classifier qc_checker #(
   .TID_W(TID_W), .PRI_W(PRI_W), .BANK_W(BANK_W), .VDEV_W(VDEV_W),
   .VPORT_DEPTH(VPORT_DEPTH), .CFG_AW(CFG_AW)
) u_chk (.*);

// File: tb/qos_desc_classifier_test.sv
`timescale 1ns/1ps
module qos_desc_classifier_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  in_drop_prec = '0;
   logic        in_qos_flag = 1'b0;
   logic [7:0]  in_qos = '0;
   logic [3:0]  in_int_pri = '0;
   logic [15:0] in_dst_word = '0;
   logic [15:0] in_src_word = '0;
   logic        cfg_we = 1'b0;
   logic        cfg_tbl = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [16:0] cfg_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        out_err;
   logic [2:0]  out_tid;
   logic        out_tid_en;
   logic        out_flow;
   logic        out_flow_en;
   logic [1:0]  out_cls_sel;
   logic [1:0]  out_color;
   logic [7:0]  out_port_id;
   logic [5:0]  out_bank;
   logic [7:0]  out_vdev;
   logic        out_to_fw;

   always #5 clk = ~clk;

   qos_desc_classifier uut (.*);

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int t_tid [16];
   int a_bank [192], a_vdev [192], a_fw [192], a_drop [192], a_prio [192];
   bit m_valid, m_err, m_tid_en, m_flow, m_flow_en, m_fw;
   int m_tid, m_cls, m_col, m_port, m_bank, m_vdev;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid = 0;
         foreach (t_tid[i]) t_tid[i] = 0;
         for (int i = 0; i < 192; i++) begin
            a_bank[i] = 0; a_vdev[i] = 0; a_fw[i] = 0; a_drop[i] = 0; a_prio[i] = 0;
         end
      end else begin
         if (in_valid && (!m_valid || out_ready)) begin
            int d, s, vi;
            bit ok, vp, pen, den;
            d  = int'(in_dst_word[11:0]);
            s  = int'(in_src_word[11:0]);
            vp = (in_dst_word[15:12] == 4'd2) && d >= 64 && d < 256;
            ok = (in_dst_word[15:12] == 4'd2) && (d < 32 || vp)
                 && (in_src_word[15:12] == 4'd2) && s < 256;
            vi = vp ? d - 64 : 0;
            pen = vp && a_prio[vi] != 0;
            den = vp && a_drop[vi] != 0;
            m_valid = 1;
            m_err = !ok;
            m_tid = 0; m_tid_en = 0; m_flow = 0; m_flow_en = 0; m_cls = 0;
            m_col = 3; m_port = 0; m_bank = 0; m_vdev = 0; m_fw = 0;
            if (ok) begin
               m_port = d;
               if (vp) begin m_bank = a_bank[vi]; m_vdev = a_vdev[vi]; m_fw = a_fw[vi] != 0; end
               if (in_qos_flag) begin
                  m_cls = in_qos[5:4]; m_tid = in_qos[3:1]; m_flow = in_qos[0];
                  m_tid_en = 1; m_flow_en = 1;
               end else if (in_qos[7]) begin
                  m_tid = in_qos[3:1]; m_tid_en = 1;
               end else if (pen) begin
                  m_tid = t_tid[in_int_pri]; m_tid_en = 1;
               end
               if (den && in_drop_prec != 2'd3) m_col = in_drop_prec;
            end
         end else if (out_ready) begin
            m_valid = 0;
         end
         if (cfg_we) begin
            if (!cfg_tbl && cfg_addr < 16) t_tid[cfg_addr] = cfg_data[2:0];
            if (cfg_tbl && cfg_addr < 192) begin
               a_bank[cfg_addr] = cfg_data[5:0];
               a_vdev[cfg_addr] = cfg_data[13:6];
               a_fw[cfg_addr]   = cfg_data[14];
               a_drop[cfg_addr] = cfg_data[15];
               a_prio[cfg_addr] = cfg_data[16];
            end
         end
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R1 in_ready", in_ready, (!m_valid || out_ready));
         check("R1 out_valid", out_valid, m_valid);
         if (m_valid && out_valid) begin
            check("R8 R9 R10 out_err", out_err, m_err);
            check("R2 R3 R4 R5 out_tid", out_tid, m_tid);
            check("R2 R3 R4 R5 out_tid_en", out_tid_en, m_tid_en);
            check("R2 R3 R5 out_flow", out_flow, m_flow);
            check("R2 R3 R5 out_flow_en", out_flow_en, m_flow_en);
            check("R2 R3 out_cls_sel", out_cls_sel, m_cls);
            check("R7 R11 out_color", out_color, m_col);
            check("R9 out_port_id", out_port_id, m_port);
            check("R9 R12 out_bank", out_bank, m_bank);
            check("R9 R12 out_vdev", out_vdev, m_vdev);
            check("R9 R12 out_to_fw", out_to_fw, m_fw);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic write_cfg(bit tbl, int addr, int data);
      cfg_we = 1; cfg_tbl = tbl; cfg_addr = 8'(addr); cfg_data = 17'(data);
      tick();
      cfg_we = 0;
   endtask

   task automatic send(bit flag, int qos, int drop, int pri, int dst, int src);
      in_valid = 1; in_qos_flag = flag; in_qos = 8'(qos); in_drop_prec = 2'(drop);
      in_int_pri = 4'(pri); in_dst_word = 16'(dst); in_src_word = 16'(src);
      tick();
      in_valid = 0;
   endtask

   function automatic int rand_dst();
      int k = $urandom_range(0, 9);
      if (k == 0) return ({$urandom_range(0, 15)} != 2) ? 0 : 0;
      if (k == 1) return ($urandom_range(0, 1) ? 16'h1000 : 16'h3000) | $urandom_range(64, 255);
      if (k == 2) return 16'h2000 | $urandom_range(0, 31);
      if (k == 3) return 16'h2000 | $urandom_range(32, 63);
      if (k == 4) return 16'h2000 | $urandom_range(256, 4095);
      if (k <= 6) return 16'h2000 | $urandom_range(64, 67);
      return 16'h2000 | $urandom_range(64, 255);
   endfunction

   function automatic int rand_src();
      int k = $urandom_range(0, 9);
      if (k == 0) return 16'h4000 | $urandom_range(0, 255);
      if (k == 1) return 16'h2000 | $urandom_range(256, 4095);
      return 16'h2000 | $urandom_range(0, 255);
   endfunction

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int t6a, t6b;
      void'($urandom(7));
      repeat (3) @(posedge clk);
      #1;
      // R13 reset state
      check("R13 out_valid after reset", out_valid, 0);
      check("R13 in_ready after reset", in_ready, 1);
      rst_n = 1;
      tick();
      out_ready = 1;

      // R13 tables cleared: vport with zero attributes, no enables
      send(0, 8'h05, 1, 3, 16'h2000 | 100, 16'h2005);
      tick();

      // program tables (R12)
      for (int i = 0; i < 16; i++) write_cfg(0, i, (i * 5 + 3) & 7);
      for (int i = 0; i < 192; i++)
         write_cfg(1, i, ((i & 1) << 16) | (((i >> 1) & 1) << 15) | (((i >> 2) & 1) << 14)
                         | (((i * 7) & 255) << 6) | (i & 63));
      // R12 out-of-range writes must not alias to low entries
      write_cfg(1, 200, 17'h1ffff);
      write_cfg(0, 20, 7);
      send(0, 8'h00, 0, 4, 16'h2000 | 72, 16'h2001);   // vport index 8
      send(0, 8'h00, 0, 4, 16'h2000 | 65, 16'h2001);   // R4 table path
      send(1, 8'h3b, 2, 0, 16'h2000 | 67, 16'h2002);   // R2
      send(0, 8'h86, 1, 0, 16'h2000 | 67, 16'h2002);   // R3 + R7 yellow
      send(0, 8'h00, 3, 0, 16'h2000 | 67, 16'h2002);   // R7 drop 3 -> colourless
      send(0, 8'h00, 0, 0, 16'h2000 | 10, 16'h2002);   // R5 physical port
      send(0, 8'h00, 0, 0, 16'h2000 | 40, 16'h2002);   // R9 LAG error
      send(0, 8'h00, 0, 0, 16'h1000 | 70, 16'h2002);   // R8 next hop error
      send(0, 8'h00, 0, 0, 16'h2000 | 70, 16'h2000 | 300); // R10
      tick();

      // R6: bit 6 must not matter
      out_ready = 1;
      send(1, 8'h2d, 0, 0, 16'h2000 | 66, 16'h2003);
      t6a = {out_tid, out_flow, out_cls_sel, out_tid_en, out_flow_en, out_color};
      send(1, 8'h6d, 0, 0, 16'h2000 | 66, 16'h2003);
      t6b = {out_tid, out_flow, out_cls_sel, out_tid_en, out_flow_en, out_color};
      check("R6 qos bit6 ignored (flag)", t6b, t6a);
      send(0, 8'h8a, 0, 0, 16'h2000 | 66, 16'h2003);
      t6a = {out_tid, out_flow, out_cls_sel, out_tid_en, out_flow_en, out_color};
      send(0, 8'hca, 0, 0, 16'h2000 | 66, 16'h2003);
      t6b = {out_tid, out_flow, out_cls_sel, out_tid_en, out_flow_en, out_color};
      check("R6 qos bit6 ignored (top bit)", t6b, t6a);

      // random traffic with backpressure and table writes in flight
      for (int n = 0; n < 4000; n++) begin
         in_valid     = ($urandom_range(0, 9) < 8);
         in_qos_flag  = $urandom_range(0, 3) == 0;
         in_qos       = 8'($urandom);
         in_drop_prec = 2'($urandom);
         in_int_pri   = 4'($urandom);
         in_dst_word  = 16'(rand_dst());
         in_src_word  = 16'(rand_src());
         out_ready    = ($urandom_range(0, 9) < 6);
         cfg_we       = ($urandom_range(0, 7) == 0);
         cfg_tbl      = $urandom_range(0, 1);
         cfg_addr     = cfg_tbl ? 8'($urandom_range(0, 5)) : 8'($urandom_range(0, 17));
         if ($urandom_range(0, 15) == 0) cfg_addr = 8'($urandom_range(192, 255));
         cfg_data     = 17'($urandom);
         tick();
      end
      in_valid = 0; cfg_we = 0; out_ready = 1;
      repeat (3) tick();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule